// File: doc/BRIEF.md
# Valid-Invalid Snooping Coherence Controller

This block is the coherence engine for one core's private, direct-mapped, write-back cache. Each line is either held (valid) or not held (invalid); a single valid bit per line carries that state. A load or store from the core that finds its line valid completes at once with no bus traffic. A miss is sent on a shared snooping bus as a load-miss or store-miss. If the line in that slot is dirty and holds another address, a writeback is sent first. The line becomes valid when the fill data returns.

Each controller also watches the misses that other cores broadcast. If a remote miss names a line this cache holds, the controller drives the line data onto its snoop response in the same cycle and drops the line. If the line is dirty, the controller also flags a writeback so that memory is updated. A remote miss therefore always takes the only copy, and two caches never hold the same block at once. When no cache answers, memory supplies the data. The arbiter and the memory sit outside the block. One instance is placed per core.

Top module: `vi_snoop_ctrl`

## Requirements
- R1: Every line has one valid bit, and all lines are invalid after reset, so the first access to any address is a miss. The line index is the low IDX_W address bits and the tag is the remaining upper bits.
- R2: A miss on an invalid line raises a bus request with command 2'b01 for a load or 2'b10 for a store. The line is valid after the response, and the access then completes as a hit on the next cycle.
- R3: A load or store to a valid line with a matching tag is acknowledged in the cycle the request is presented, with bus_req_o low. A store hit writes the line.
- R4: When another core's load-miss or store-miss hits a valid line here, snp_hit_o is high and snp_data_o carries the line in that cycle. The line is invalid from the next cycle.
- R5: A dirty line that is given up to a snoop raises snp_wb_o together with snp_hit_o. When a miss replaces a dirty line of another address, a writeback (command 2'b11) carrying the victim's address and data is sent before the miss.
- R6: When no cache answers a miss, the fill data is the memory value.
- R7: At most one cache holds a valid copy of a block. A core whose line was taken by a remote miss misses again on its next access to that address.
- R8: A store sets the line's dirty bit. A fill or a writeback leaves the line clean. A clean victim is replaced without a writeback, and a clean line given to a snoop does not raise snp_wb_o.
- R9: bus_req_o stays high from the first request of a transaction until its response. A bus message takes effect only in its grant cycle. With the bus idle, an isolated miss is acknowledged after the fourth rising clock edge that follows the request.
- R10: Every load returns the value of the most recent store to that address, in the order in which stores complete across all cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_req_i | input | 1 | Core access request, held until acknowledged |
| core_we_i | input | 1 | 1 = store, 0 = load |
| core_addr_i | input | ADDR_W | Word address of the access |
| core_wdata_i | input | DATA_W | Store data |
| core_ack_o | output | 1 | Access completes at this clock edge |
| core_rdata_o | output | DATA_W | Load data, valid with core_ack_o |
| bus_req_o | output | 1 | Bus request, held until the response |
| bus_gnt_i | input | 1 | One-cycle grant; the message is broadcast in this cycle |
| bus_cmd_o | output | 2 | 01 load-miss, 10 store-miss, 11 writeback |
| bus_addr_o | output | ADDR_W | Message address |
| bus_data_o | output | DATA_W | Writeback data |
| bus_resp_i | input | 1 | One-cycle response to this core's message |
| bus_resp_data_i | input | DATA_W | Fill data with the response |
| snp_valid_i | input | 1 | Another core's message is on the bus |
| snp_cmd_i | input | 2 | Command of the observed message |
| snp_addr_i | input | ADDR_W | Address of the observed message |
| snp_hit_o | output | 1 | This cache supplies the line |
| snp_wb_o | output | 1 | The supplied line is dirty; memory must take it |
| snp_data_o | output | DATA_W | Supplied line data |

## Verification
Two instances share a bench arbiter and memory. A directed opening covers the cases one at a time: a cold load, then a load hit and a store hit, then a dirty hand-over to the other core, a clean hand-back, dirty and clean conflict evictions, and a writeback that lands in memory. Cycle counts and per-core bus message counts show whether each access was a hit, a plain miss or a miss with a writeback. A sweep over all 64 addresses alternates a store on one core with a load on the other and a reload on the first. It tells dirty supply apart from clean supply, and it shows that the first holder loses its copy. A concurrent phase runs both cores on overlapping addresses with mixed loads and stores. Every load is compared with a reference model that is updated in store completion order, and a final read of the whole space checks that value order is kept.

// File: rtl/vi_pkg.sv
package vi_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_LDMISS = 2'b01,
    CMD_STMISS = 2'b10,
    CMD_WB     = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10
  } ctrl_st_e;
endpackage

// File: rtl/vi_line_store.sv
module vi_line_store #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int NLINES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic              inv_en_i,
  input  logic              wr_en_i,
  input  logic              wr_valid_i,
  input  logic              wr_dirty_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sn_valid_o,
  output logic              sn_dirty_o,
  output logic [TAG_W-1:0]  sn_tag_o,
  output logic [DATA_W-1:0] sn_data_o,
  output logic [NLINES-1:0] valid_vec_o
);
  logic [NLINES-1:0] dirty_vec;
  logic [TAG_W-1:0]  tag_arr  [NLINES];
  logic [DATA_W-1:0] data_arr [NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic              valid_q, dirty_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;

    // snoop invalidate and core write never target one line in one cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
        tag_q   <= '0;
        data_q  <= '0;
      end else if (inv_en_i && snp_idx_i == IDX_W'(i)) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
      end else if (wr_en_i && rd_idx_i == IDX_W'(i)) begin
        valid_q <= wr_valid_i;
        dirty_q <= wr_dirty_i;
        tag_q   <= wr_tag_i;
        data_q  <= wr_data_i;
      end
    end

    assign valid_vec_o[i] = valid_q;
    assign dirty_vec[i]   = dirty_q;
    assign tag_arr[i]     = tag_q;
    assign data_arr[i]    = data_q;
  end

  assign rd_valid_o = valid_vec_o[rd_idx_i];
  assign rd_dirty_o = dirty_vec[rd_idx_i];
  assign rd_tag_o   = tag_arr[rd_idx_i];
  assign rd_data_o  = data_arr[rd_idx_i];
  assign sn_valid_o = valid_vec_o[snp_idx_i];
  assign sn_dirty_o = dirty_vec[snp_idx_i];
  assign sn_tag_o   = tag_arr[snp_idx_i];
  assign sn_data_o  = data_arr[snp_idx_i];
endmodule

// File: rtl/vi_snoop_match.sv
module vi_snoop_match #(
  parameter int TAG_W = 4
) (
  input  logic             snp_valid_i,
  input  logic [1:0]       snp_cmd_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic             line_valid_i,
  input  logic             line_dirty_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             hit_o,
  output logic             wb_o
);
  import vi_pkg::*;
  logic is_miss;

  always_comb begin
    is_miss = (snp_cmd_i == CMD_LDMISS) || (snp_cmd_i == CMD_STMISS);
    hit_o   = snp_valid_i && is_miss && line_valid_i && (line_tag_i == snp_tag_i);
    wb_o    = hit_o && line_dirty_i;
  end
endmodule

// File: rtl/vi_ctrl_fsm.sv
module vi_ctrl_fsm #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_req_i,
  input  logic              core_we_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic              core_ack_o,
  input  logic              line_valid_i,
  input  logic              line_dirty_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              snp_valid_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              bus_resp_i,
  input  logic [DATA_W-1:0] bus_resp_data_i,
  output logic              wr_en_o,
  output logic              wr_valid_o,
  output logic              wr_dirty_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o
);
  import vi_pkg::*;

  ctrl_st_e   st_q;
  bus_cmd_e   cmd_q, miss_cmd;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic hit, clash, victim_dirty;

  always_comb begin
    idx          = core_addr_i[IDX_W-1:0];
    tag          = core_addr_i[ADDR_W-1:IDX_W];
    hit          = line_valid_i && (line_tag_i == tag);
    clash        = snp_valid_i && (snp_idx_i == idx);
    victim_dirty = line_valid_i && line_dirty_i && (line_tag_i != tag);
    miss_cmd     = core_we_i ? CMD_STMISS : CMD_LDMISS;
    core_ack_o   = (st_q == ST_IDLE) && core_req_i && hit && !clash;
    bus_req_o    = (st_q != ST_IDLE);
    bus_cmd_o    = bus_req_o ? cmd_q : CMD_NONE;
    bus_addr_o   = (cmd_q == CMD_WB) ? {line_tag_i, idx} : core_addr_i;

    wr_en_o    = 1'b0;
    wr_valid_o = line_valid_i;
    wr_dirty_o = line_dirty_i;
    wr_tag_o   = line_tag_i;
    wr_data_o  = line_data_i;
    if (core_ack_o && core_we_i) begin
      wr_en_o    = 1'b1;
      wr_dirty_o = 1'b1;
      wr_data_o  = core_wdata_i;
    end else if (st_q == ST_WAIT && bus_resp_i) begin
      wr_en_o    = 1'b1;
      wr_dirty_o = 1'b0;
      if (cmd_q == CMD_WB) begin
        wr_valid_o = 1'b0;
      end else begin
        wr_valid_o = 1'b1;
        wr_tag_o   = tag;
        wr_data_o  = bus_resp_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cmd_q <= CMD_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (core_req_i && !hit && !clash) begin
          cmd_q <= victim_dirty ? CMD_WB : miss_cmd;
          st_q  <= ST_REQ;
        end
        ST_REQ: begin
          // victim may be taken by a snoop before our writeback is granted
          if (cmd_q == CMD_WB && !victim_dirty) cmd_q <= miss_cmd;
          else if (bus_gnt_i)                   st_q  <= ST_WAIT;
        end
        ST_WAIT: if (bus_resp_i) begin
          if (cmd_q == CMD_WB) begin
            cmd_q <= miss_cmd;
            st_q  <= ST_REQ;
          end else begin
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vi_snoop_ctrl.sv
module vi_snoop_ctrl #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int NLINES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_req_i,
  input  logic              core_we_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic              core_ack_o,
  output logic [DATA_W-1:0] core_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_resp_i,
  input  logic [DATA_W-1:0] bus_resp_data_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_hit_o,
  output logic              snp_wb_o,
  output logic [DATA_W-1:0] snp_data_o
);
  logic              rd_valid, rd_dirty, sn_valid, sn_dirty;
  logic [TAG_W-1:0]  rd_tag, sn_tag, wr_tag;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, wr_valid, wr_dirty;
  logic [NLINES-1:0] valid_vec;

  vi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i   (core_addr_i[IDX_W-1:0]),
    .snp_idx_i  (snp_addr_i[IDX_W-1:0]),
    .inv_en_i   (snp_hit_o),
    .wr_en_i    (wr_en),
    .wr_valid_i (wr_valid),
    .wr_dirty_i (wr_dirty),
    .wr_tag_i   (wr_tag),
    .wr_data_i  (wr_data),
    .rd_valid_o (rd_valid),
    .rd_dirty_o (rd_dirty),
    .rd_tag_o   (rd_tag),
    .rd_data_o  (rd_data),
    .sn_valid_o (sn_valid),
    .sn_dirty_o (sn_dirty),
    .sn_tag_o   (sn_tag),
    .sn_data_o  (snp_data_o),
    .valid_vec_o(valid_vec)
  );

  vi_snoop_match #(.TAG_W(TAG_W)) u_match (
    .snp_valid_i,
    .snp_cmd_i,
    .snp_tag_i   (snp_addr_i[ADDR_W-1:IDX_W]),
    .line_valid_i(sn_valid),
    .line_dirty_i(sn_dirty),
    .line_tag_i  (sn_tag),
    .hit_o       (snp_hit_o),
    .wb_o        (snp_wb_o)
  );

  vi_ctrl_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .core_req_i, .core_we_i, .core_addr_i, .core_wdata_i, .core_ack_o,
    .line_valid_i   (rd_valid),
    .line_dirty_i   (rd_dirty),
    .line_tag_i     (rd_tag),
    .line_data_i    (rd_data),
    .snp_valid_i,
    .snp_idx_i      (snp_addr_i[IDX_W-1:0]),
    .bus_req_o, .bus_cmd_o, .bus_addr_o,
    .bus_gnt_i, .bus_resp_i, .bus_resp_data_i,
    .wr_en_o        (wr_en),
    .wr_valid_o     (wr_valid),
    .wr_dirty_o     (wr_dirty),
    .wr_tag_o       (wr_tag),
    .wr_data_o      (wr_data)
  );

  assign core_rdata_o = rd_data;
  assign bus_data_o   = rd_data;
endmodule

// File: rtl/vi_snoop_chk.sv
module vi_snoop_chk #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  localparam int NLINES = 1 << IDX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              core_req_i,
  input logic              core_ack_o,
  input logic              bus_req_o,
  input logic              bus_resp_i,
  input logic [1:0]        bus_cmd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              snp_hit_o,
  input logic              snp_wb_o,
  input logic [NLINES-1:0] valid_vec
);
  logic [IDX_W-1:0] snp_idx_q, fill_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snp_idx_q  <= '0;
      fill_idx_q <= '0;
    end else begin
      snp_idx_q  <= snp_addr_i[IDX_W-1:0];
      fill_idx_q <= bus_addr_o[IDX_W-1:0];
    end
  end

  AST_HIT_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ack_o |-> (!bus_req_o && core_req_i)); // R3
  AST_FILL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_resp_i && bus_cmd_o != 2'b11) |=> valid_vec[fill_idx_q]); // R2
  AST_SNOOP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_o |=> !valid_vec[snp_idx_q]); // R4
  AST_WB_WITH_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_wb_o |-> snp_hit_o); // R5
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_resp_i) |=> bus_req_o); // R9
  AST_CMD_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_cmd_o != 2'b00)); // R9
endmodule

bind vi_snoop_ctrl vi_snoop_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .core_req_i (core_req_i),
  .core_ack_o (core_ack_o),
  .bus_req_o  (bus_req_o),
  .bus_resp_i (bus_resp_i),
  .bus_cmd_o  (bus_cmd_o),
  .bus_addr_o (bus_addr_o),
  .snp_addr_i (snp_addr_i),
  .snp_hit_o  (snp_hit_o),
  .snp_wb_o   (snp_wb_o),
  .valid_vec  (valid_vec)
);

// File: tb/sim_vi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_vi_snoop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int IW = 2;
  localparam int DW = 16;
  localparam int NA = 1 << AW;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          req [NC], we [NC], ack [NC], breq [NC], gnt [NC], resp [NC];
  logic          shit [NC], swb [NC];
  logic [AW-1:0] addr [NC], baddr [NC];
  logic [DW-1:0] wdata [NC], rdata [NC], bdata [NC], sdata [NC], rsp_data;
  logic [1:0]    bcmd [NC];

  logic [DW-1:0] bus_mem [NA];
  logic [DW-1:0] ref_mem [NA];
  int msg_cnt [NC], wb_cnt [NC], sup_cnt [NC], supwb_cnt [NC];
  int last_cmd [NC];
  logic busy;
  int tests = 0, fails = 0;

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 7 + 3);
  endfunction

  for (genvar c = 0; c < NC; c++) begin : g_core
    vi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .core_req_i(req[c]), .core_we_i(we[c]), .core_addr_i(addr[c]),
      .core_wdata_i(wdata[c]), .core_ack_o(ack[c]), .core_rdata_o(rdata[c]),
      .bus_req_o(breq[c]), .bus_gnt_i(gnt[c]), .bus_cmd_o(bcmd[c]),
      .bus_addr_o(baddr[c]), .bus_data_o(bdata[c]),
      .bus_resp_i(resp[c]), .bus_resp_data_i(rsp_data),
      .snp_valid_i(gnt[NC-1-c]), .snp_cmd_i(bcmd[NC-1-c]), .snp_addr_i(baddr[NC-1-c]),
      .snp_hit_o(shit[c]), .snp_wb_o(swb[c]), .snp_data_o(sdata[c])
    );
  end

  // arbiter and memory
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        gnt[i] <= 1'b0; resp[i] <= 1'b0;
        msg_cnt[i] <= 0; wb_cnt[i] <= 0; sup_cnt[i] <= 0; supwb_cnt[i] <= 0; last_cmd[i] <= 0;
      end
      busy <= 1'b0;
      rsp_data <= '0;
      for (int a = 0; a < NA; a++) bus_mem[a] <= init_val(a);
    end else begin
      for (int i = 0; i < NC; i++) begin gnt[i] <= 1'b0; resp[i] <= 1'b0; end
      if (gnt[0] || gnt[1]) begin
        automatic int o = gnt[0] ? 0 : 1;
        automatic int p = 1 - o;
        msg_cnt[o] <= msg_cnt[o] + 1;
        last_cmd[o] <= int'(bcmd[o]);
        resp[o] <= 1'b1;
        if (bcmd[o] == 2'b11) begin
          wb_cnt[o] <= wb_cnt[o] + 1;
          bus_mem[baddr[o]] <= bdata[o];
        end else if (shit[p]) begin
          sup_cnt[p] <= sup_cnt[p] + 1;
          rsp_data <= sdata[p];
          if (swb[p]) begin
            supwb_cnt[p] <= supwb_cnt[p] + 1;
            bus_mem[baddr[o]] <= sdata[p];
          end
        end else begin
          rsp_data <= bus_mem[baddr[o]];
        end
      end else if (resp[0] || resp[1]) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (breq[0])      begin gnt[0] <= 1'b1; busy <= 1'b1; end
        else if (breq[1]) begin gnt[1] <= 1'b1; busy <= 1'b1; end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_op(input int c, input bit w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] rd, output int waits);
    @(negedge clk);
    req[c] = 1'b1; we[c] = w; addr[c] = a; wdata[c] = d;
    waits = 0;
    #1;
    while (!ack[c]) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = rdata[c];
    @(posedge clk);
    if (w) ref_mem[a] = d;
    #1 req[c] = 1'b0;
  endtask

  // load compared with the reference in completion order
  task automatic ld_chk(input int c, input logic [AW-1:0] a, input string rq);
    logic [DW-1:0] rd, exp;
    int wt;
    @(negedge clk);
    req[c] = 1'b1; we[c] = 1'b0; addr[c] = a; wdata[c] = '0;
    #1;
    while (!ack[c]) begin @(negedge clk); #1; end
    rd = rdata[c];
    exp = ref_mem[a];
    @(posedge clk);
    #1 req[c] = 1'b0;
    wt = 0;
    chk(rd == exp, rq, int'(rd), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int wt, m0, m1, s0, sw0, w0;
    for (int i = 0; i < NC; i++) begin req[i] = 0; we[i] = 0; addr[i] = '0; wdata[i] = '0; end
    for (int a = 0; a < NA; a++) ref_mem[a] = init_val(a);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!breq[0] && !breq[1], "R9 idle after reset", int'(breq[0]) + int'(breq[1]), 0);
    chk(!ack[0] && !ack[1], "R1 no ack after reset", int'(ack[0]) + int'(ack[1]), 0);

    // cold load
    m0 = msg_cnt[0];
    do_op(0, 0, 6'd5, '0, rd, wt);
    chk(msg_cnt[0] == m0 + 1, "R1 cold miss message", msg_cnt[0] - m0, 1);
    chk(last_cmd[0] == 1, "R2 load-miss code", last_cmd[0], 1);
    chk(wt == 4, "R9 miss latency", wt, 4);
    chk(rd == init_val(5), "R6 memory fill", int'(rd), int'(init_val(5)));
    // hits
    m0 = msg_cnt[0];
    do_op(0, 0, 6'd5, '0, rd, wt);
    chk(wt == 0 && msg_cnt[0] == m0, "R3 load hit", wt, 0);
    do_op(0, 1, 6'd5, 16'hBEEF, rd, wt);
    chk(wt == 0 && msg_cnt[0] == m0, "R3 store hit", wt, 0);
    // dirty hand-over
    sw0 = supwb_cnt[0];
    do_op(1, 0, 6'd5, '0, rd, wt);
    chk(rd == 16'hBEEF, "R4 supplied data", int'(rd), 16'hBEEF);
    chk(supwb_cnt[0] == sw0 + 1, "R5 dirty supply flags writeback", supwb_cnt[0] - sw0, 1);
    chk(bus_mem[5] == 16'hBEEF, "R5 memory updated", int'(bus_mem[5]), 16'hBEEF);
    // hand back clean
    m0 = msg_cnt[0];
    do_op(0, 0, 6'd5, '0, rd, wt);
    chk(msg_cnt[0] == m0 + 1, "R7 copy was taken", msg_cnt[0] - m0, 1);
    chk(supwb_cnt[1] == 0 && sup_cnt[1] == 1, "R8 clean supply no writeback", supwb_cnt[1], 0);
    // store miss into index 1 (line 5 clean in core0, core1 line gone)
    m0 = msg_cnt[0]; w0 = wb_cnt[0];
    do_op(0, 1, 6'd9, 16'h1111, rd, wt);
    chk(msg_cnt[0] == m0 + 1 && wb_cnt[0] == w0, "R8 clean victim silent", msg_cnt[0] - m0, 1);
    chk(last_cmd[0] == 2, "R2 store-miss code", last_cmd[0], 2);
    // dirty conflict eviction
    m0 = msg_cnt[0];
    do_op(0, 1, 6'd13, 16'h2222, rd, wt);
    chk(wb_cnt[0] == w0 + 1 && msg_cnt[0] == m0 + 2, "R5 eviction writeback", wb_cnt[0] - w0, 1);
    chk(wt == 7, "R9 writeback plus miss latency", wt, 7);
    chk(bus_mem[9] == 16'h1111, "R5 victim data in memory", int'(bus_mem[9]), 16'h1111);
    ld_chk(0, 6'd13, "R10 store fill kept");
    ld_chk(0, 6'd9, "R10 evicted value reread");

    // sweep: store on one core, load on other, reload on first
    for (int a = 0; a < NA; a++) begin
      automatic int c = a % 2;
      automatic int o = 1 - c;
      s0 = sup_cnt[c]; sw0 = supwb_cnt[c];
      do_op(c, 1, AW'(a), DW'(a * 37 + 11), rd, wt);
      ld_chk(o, AW'(a), "R10 sweep cross load");
      chk(sup_cnt[c] == s0 + 1 && supwb_cnt[c] == sw0 + 1, "R5 sweep dirty supply",
          supwb_cnt[c] - sw0, 1);
      m1 = msg_cnt[c]; s0 = supwb_cnt[o];
      ld_chk(c, AW'(a), "R4 sweep reload");
      chk(msg_cnt[c] == m1 + 1, "R7 sweep reload misses", msg_cnt[c] - m1, 1);
      chk(supwb_cnt[o] == s0, "R8 sweep clean supply", supwb_cnt[o] - s0, 0);
    end

    // concurrent traffic
    fork
      begin
        for (int k = 0; k < 120; k++) begin
          automatic logic [AW-1:0] a = AW'((k * 13) % 24);
          if (k % 3 == 0) do_op(0, 1, a, DW'(1000 + k), rd, wt);
          else ld_chk(0, a, "R10 concurrent core0");
        end
      end
      begin
        logic [DW-1:0] rd1;
        int wt1;
        for (int k = 0; k < 120; k++) begin
          automatic logic [AW-1:0] a = AW'((k * 7 + 3) % 24);
          if (k % 3 == 1) do_op(1, 1, a, DW'(3000 + k), rd1, wt1);
          else ld_chk(1, a, "R10 concurrent core1");
        end
      end
    join

    for (int a = 0; a < NA; a++) ld_chk(0, AW'(a), "R10 final read core0");
    s0 = sup_cnt[0];
    for (int a = NA - 4; a < NA; a++) ld_chk(1, AW'(a), "R7 final read core1");
    chk(sup_cnt[0] == s0 + 4, "R7 single copy moves", sup_cnt[0] - s0, 4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule